// File: doc/BRIEF.md
# Interrupt Pending and Active Tracker

This block keeps three bits of state for each of `NUM_IRQ` level-sensitive interrupt lines: an enable, a pending latch and an active flag. A line that goes high latches a request that outlives the line itself. Several pulses before service fold into one request. The core acknowledges an interrupt by number to start its handler, and signals a return by number to retire it. If the line is still high at that return, the request is latched again.

Software reaches the state through a word-wide register port. The address splits into a 3-bit region in `bus_addr[7:5]` and a word index in `bus_addr[4:0]`, and word `w` covers interrupts `32*w` to `32*w+31`. Enable and pending each have one region that sets bits and another that clears them, and both regions of a pair read back the current state. A trigger region pends one interrupt, given by number. The core sees the vector of requests that are both pending and enabled, and the vector of active interrupts. Priority arbitration and vector fetch are done outside this block.

Top module: `irq_state_tracker`

## Requirements
- R1: After reset every enable, pending and active bit is 0, so `req_vec`, `active_vec` and every readback word are 0.
- R2: A line sampled high while its interrupt is not active sets the pending bit at that clock edge, and the bit stays set after the line falls.
- R3: Any number of pulses on a line before its acknowledge leave one request: after one acknowledge the pending bit is 0 and stays 0 while the line stays low.
- R4: A write to region 0 (enable set) sets each enable bit whose data bit is 1, and a write to region 1 (enable clear) clears them; data bits at 0 change nothing. Regions 0 and 1 both read back the enable word, and `req_vec` equals pending AND enable.
- R5: A write to region 2 (pending set) sets each pending bit whose data bit is 1, and a write to region 3 (pending clear) clears them, which cancels a request not yet acknowledged. Regions 2 and 3 both read back the pending word.
- R6: A write of value k to region 5 (trigger) sets pending bit k when k < `NUM_IRQ`. A larger value changes nothing.
- R7: `ack_valid` with `ack_id` = k sets active bit k and clears pending bit k at the same edge, even while line k is high.
- R8: `ret_valid` with `ret_id` = k clears active bit k. If line k is high in that cycle, pending bit k is set at the same edge.
- R9: While an interrupt is active, a new rising edge on its line sets the pending bit. A line that has stayed high since before the acknowledge does not.
- R10: When a hardware set and a pending-clear write hit the same bit in the same cycle, the bit ends up set.
- R11: Region 4 reads back the active word and ignores writes. Regions 6 and 7, and word indices at or beyond the implemented count, read 0. Bits at or above `NUM_IRQ` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_lines | input | NUM_IRQ | Level interrupt inputs |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Region in the top 3 bits, word index below |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| ack_valid | input | 1 | Core enters a handler |
| ack_id | input | ID_W | Interrupt number being entered |
| ret_valid | input | 1 | Core leaves a handler |
| ret_id | input | ID_W | Interrupt number being retired |
| req_vec | output | NUM_IRQ | Pending and enabled requests |
| active_vec | output | NUM_IRQ | Active flags |

## Verification
Directed sequences each target one behaviour of the pending latch. A single short pulse shows that the latch holds after the line falls. A burst of pulses followed by one acknowledge tells a merged request apart from a counted one. A line held high through a whole handler is set against a line that falls and rises again inside the handler, which separates re-pending at exit from re-pending on a new edge. A line edge in the same cycle as a clear write exposes the set-versus-clear priority. After these, a seeded random run mixes sparse line toggles, writes to every region including unused ones and out-of-range trigger numbers, and random acknowledges and returns. A bench reference model checks both vectors every cycle and the readback for a random address.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;

    typedef enum logic [2:0] {
        RGN_ENA_SET = 3'd0,
        RGN_ENA_CLR = 3'd1,
        RGN_PND_SET = 3'd2,
        RGN_PND_CLR = 3'd3,
        RGN_ACTIVE  = 3'd4,
        RGN_TRIGGER = 3'd5,
        RGN_SPARE6  = 3'd6,
        RGN_SPARE7  = 3'd7
    } region_e;

    // Registered state of one interrupt line.
    typedef struct packed {
        logic ena;
        logic pend;
        logic act;
        logic prev;   // line level sampled at the previous edge
    } cell_state_t;

    // Per-line commands decoded from the bus and the core.
    typedef struct packed {
        logic ena_set;
        logic ena_clr;
        logic pnd_set;
        logic pnd_clr;
        logic ack;
        logic ret;
    } cell_cmd_t;

endpackage

// File: rtl/irq_cmd_decode.sv
module irq_cmd_decode
    import irq_trk_pkg::*;
#(
    parameter int NUM_IRQ = 40,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 8,
    parameter int ID_W    = 6
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              ack_valid,
    input  logic [ID_W-1:0]   ack_id,
    input  logic              ret_valid,
    input  logic [ID_W-1:0]   ret_id,
    output cell_cmd_t         cmd_o [NUM_IRQ]
);

    localparam int WSEL_W = ADDR_W - 3;

    region_e           rgn;
    logic [WSEL_W-1:0] word_sel;

    assign rgn      = region_e'(bus_addr[ADDR_W-1 -: 3]);
    assign word_sel = bus_addr[WSEL_W-1:0];

    logic wr_ena_set, wr_ena_clr, wr_pnd_set, wr_pnd_clr, wr_trig;

    assign wr_ena_set = bus_wr && (rgn == RGN_ENA_SET);
    assign wr_ena_clr = bus_wr && (rgn == RGN_ENA_CLR);
    assign wr_pnd_set = bus_wr && (rgn == RGN_PND_SET);
    assign wr_pnd_clr = bus_wr && (rgn == RGN_PND_CLR);
    assign wr_trig    = bus_wr && (rgn == RGN_TRIGGER);

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
        localparam int WORD = g / DATA_W;
        localparam int BIT  = g % DATA_W;

        logic word_hit;
        logic data_bit;
        logic trig_hit;

        assign word_hit = (word_sel == WSEL_W'(WORD));
        assign data_bit = bus_wdata[BIT];
        assign trig_hit = wr_trig && (bus_wdata == DATA_W'(g));

        assign cmd_o[g].ena_set = wr_ena_set && word_hit && data_bit;
        assign cmd_o[g].ena_clr = wr_ena_clr && word_hit && data_bit;
        assign cmd_o[g].pnd_set = (wr_pnd_set && word_hit && data_bit) || trig_hit;
        assign cmd_o[g].pnd_clr = wr_pnd_clr && word_hit && data_bit;
        assign cmd_o[g].ack     = ack_valid && (ack_id == ID_W'(g));
        assign cmd_o[g].ret     = ret_valid && (ret_id == ID_W'(g));
    end

endmodule

// File: rtl/irq_line_cell.sv
module irq_line_cell
    import irq_trk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        line,
    input  cell_cmd_t   cmd,
    output cell_state_t state_o
);

    cell_state_t st_d, st_q;
    logic        hw_set;

    always_comb begin
        st_d      = st_q;
        st_d.prev = line;
        st_d.ena  = (st_q.ena | cmd.ena_set) & ~cmd.ena_clr;
        st_d.act  = (st_q.act & ~cmd.ret) | cmd.ack;

        // Level while idle, a new edge while active, or still high at exit.
        hw_set = line & (~st_q.act | ~st_q.prev | cmd.ret);

        if (cmd.ack)
            st_d.pend = 1'b0;
        else if (hw_set || cmd.pnd_set)
            st_d.pend = 1'b1;
        else if (cmd.pnd_clr)
            st_d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign state_o = st_q;

    // R7
    ack_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.ack |=> (st_q.act && !st_q.pend));

    // R2
    line_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line && !st_q.act && !cmd.ack) |=> st_q.pend);

    // R8
    ret_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.ret && !cmd.ack) |=> !st_q.act);

    // R8
    ret_repend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.ret && !cmd.ack && line) |=> st_q.pend);

    // R10
    set_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.pnd_clr && line && !st_q.act && !cmd.ack) |=> st_q.pend);

    // R5
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && !cmd.pnd_clr && !cmd.ack) |=> st_q.pend);

    // R9
    steady_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.act && !st_q.pend && line && st_q.prev && !cmd.ret
         && !cmd.pnd_set && !cmd.ack) |=> !st_q.pend);

    // R4
    ena_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.ena_set && !cmd.ena_clr) |=> st_q.ena);

endmodule

// File: rtl/irq_readback.sv
module irq_readback
    import irq_trk_pkg::*;
#(
    parameter int NUM_IRQ = 40,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 8
) (
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [NUM_IRQ-1:0] ena_vec,
    input  logic [NUM_IRQ-1:0] pend_vec,
    input  logic [NUM_IRQ-1:0] act_vec,
    output logic [DATA_W-1:0]  bus_rdata
);

    localparam int NUM_WORDS = (NUM_IRQ + DATA_W - 1) / DATA_W;
    localparam int PAD_W     = NUM_WORDS * DATA_W;
    localparam int WSEL_W    = ADDR_W - 3;

    logic [PAD_W-1:0] ena_pad, pend_pad, act_pad;
    region_e          rgn;
    logic [WSEL_W-1:0] word_sel;

    assign ena_pad  = PAD_W'(ena_vec);
    assign pend_pad = PAD_W'(pend_vec);
    assign act_pad  = PAD_W'(act_vec);
    assign rgn      = region_e'(bus_addr[ADDR_W-1 -: 3]);
    assign word_sel = bus_addr[WSEL_W-1:0];

    always_comb begin
        bus_rdata = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (word_sel == WSEL_W'(w)) begin
                unique case (rgn)
                    RGN_ENA_SET, RGN_ENA_CLR: bus_rdata = ena_pad[w*DATA_W +: DATA_W];
                    RGN_PND_SET, RGN_PND_CLR: bus_rdata = pend_pad[w*DATA_W +: DATA_W];
                    RGN_ACTIVE:               bus_rdata = act_pad[w*DATA_W +: DATA_W];
                    default:                  bus_rdata = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/irq_state_tracker.sv
module irq_state_tracker
    import irq_trk_pkg::*;
#(
    parameter int NUM_IRQ = 40,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 8,
    parameter int ID_W    = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_lines,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic               ack_valid,
    input  logic [ID_W-1:0]    ack_id,
    input  logic               ret_valid,
    input  logic [ID_W-1:0]    ret_id,
    output logic [NUM_IRQ-1:0] req_vec,
    output logic [NUM_IRQ-1:0] active_vec
);

    cell_cmd_t          cmd   [NUM_IRQ];
    cell_state_t        state [NUM_IRQ];
    logic [NUM_IRQ-1:0] ena_vec, pend_vec, act_vec;

    irq_cmd_decode #(
        .NUM_IRQ (NUM_IRQ),
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W),
        .ID_W    (ID_W)
    ) u_decode (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .ack_valid (ack_valid),
        .ack_id    (ack_id),
        .ret_valid (ret_valid),
        .ret_id    (ret_id),
        .cmd_o     (cmd)
    );

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_cell
        irq_line_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .line    (irq_lines[g]),
            .cmd     (cmd[g]),
            .state_o (state[g])
        );
        assign ena_vec[g]  = state[g].ena;
        assign pend_vec[g] = state[g].pend;
        assign act_vec[g]  = state[g].act;
    end

    irq_readback #(
        .NUM_IRQ (NUM_IRQ),
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W)
    ) u_readback (
        .bus_addr  (bus_addr),
        .ena_vec   (ena_vec),
        .pend_vec  (pend_vec),
        .act_vec   (act_vec),
        .bus_rdata (bus_rdata)
    );

    assign req_vec    = pend_vec & ena_vec;
    assign active_vec = act_vec;

endmodule

// File: tb/irq_state_tracker_bench.sv
`timescale 1ns/1ps
module irq_state_tracker_bench;

    localparam int N    = 40;
    localparam int IDW  = 6;
    localparam int MAXC = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_lines = '0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          ack_valid = 1'b0;
    logic [IDW-1:0] ack_id = '0;
    logic          ret_valid = 1'b0;
    logic [IDW-1:0] ret_id = '0;
    logic [N-1:0]  req_vec, active_vec;

    logic [N-1:0]  m_ena = '0, m_pend = '0, m_act = '0, m_prev = '0;
    int            vectors = 0;
    int            fails = 0;

    always #10 clk = ~clk;

    irq_state_tracker u_irq_state_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_lines  (irq_lines),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .ack_valid  (ack_valid),
        .ack_id     (ack_id),
        .ret_valid  (ret_valid),
        .ret_id     (ret_id),
        .req_vec    (req_vec),
        .active_vec (active_vec)
    );

    task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] model_read(logic [7:0] a);
        logic [63:0] e, p, c;
        int w;
        e = 64'(m_ena); p = 64'(m_pend); c = 64'(m_act);
        w = int'(a[4:0]);
        if (w >= 2) return 32'h0;
        case (a[7:5])
            3'd0, 3'd1: return e[w*32 +: 32];
            3'd2, 3'd3: return p[w*32 +: 32];
            3'd4:       return c[w*32 +: 32];
            default:    return 32'h0;
        endcase
    endfunction

    // One clock: compute the expected next state from the driven inputs,
    // let the edge pass, then compare both output vectors.
    task automatic tick();
        logic [N-1:0] ne, np, na;
        for (int i = 0; i < N; i++) begin
            bit ah, rh, inw, b, hw, ss, sc, es, ec;
            ah  = ack_valid && (int'(ack_id) == i);
            rh  = ret_valid && (int'(ret_id) == i);
            inw = (int'(bus_addr[4:0]) == i / 32);
            b   = bus_wdata[i % 32];
            hw  = irq_lines[i] && (!m_act[i] || !m_prev[i] || rh);
            ss  = bus_wr && ((bus_addr[7:5] == 3'd2 && inw && b) ||
                             (bus_addr[7:5] == 3'd5 && bus_wdata == 32'(i)));
            sc  = bus_wr && bus_addr[7:5] == 3'd3 && inw && b;
            es  = bus_wr && bus_addr[7:5] == 3'd0 && inw && b;
            ec  = bus_wr && bus_addr[7:5] == 3'd1 && inw && b;
            ne[i] = (m_ena[i] | es) & ~ec;
            na[i] = (m_act[i] & ~rh) | ah;
            if (ah)           np[i] = 1'b0;
            else if (hw || ss) np[i] = 1'b1;
            else if (sc)      np[i] = 1'b0;
            else              np[i] = m_pend[i];
        end
        @(posedge clk);
        #2;
        m_prev = irq_lines; m_ena = ne; m_pend = np; m_act = na;
        check("R4 req_vec", 64'(req_vec), 64'(m_pend & m_ena));
        check("R7 active_vec", 64'(active_vec), 64'(m_act));
        @(negedge clk);
    endtask

    task automatic idle();
        bus_wr = 1'b0; ack_valid = 1'b0; ret_valid = 1'b0;
    endtask

    task automatic wr_reg(logic [7:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        idle();
    endtask

    task automatic do_ack(int id);
        ack_valid = 1'b1; ack_id = IDW'(id);
        tick();
        idle();
    endtask

    task automatic do_ret(int id);
        ret_valid = 1'b1; ret_id = IDW'(id);
        tick();
        idle();
    endtask

    task automatic rd_check(string tag, logic [7:0] a, logic [31:0] exp);
        bus_addr = a;
        #1;
        check(tag, 64'(bus_rdata), 64'(exp));
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        #(20.0 * MAXC);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd7341));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 req_vec", 64'(req_vec), 64'h0);
        check("R1 active_vec", 64'(active_vec), 64'h0);
        rd_check("R1 ena w1", 8'h01, 32'h0);
        rd_check("R1 pend w0", 8'h40, 32'h0);
        rd_check("R1 act w0", 8'h80, 32'h0);

        // R4: set/clear enable with write-one semantics
        wr_reg(8'h00, 32'h8);
        wr_reg(8'h01, 32'h8);
        rd_check("R4 ena via set addr", 8'h00, 32'h8);
        rd_check("R4 ena via clr addr", 8'h21, 32'h8);
        wr_reg(8'h20, 32'h0);
        rd_check("R4 zero write keeps ena", 8'h00, 32'h8);

        // R2: one pulse latches and persists
        irq_lines[3] = 1'b1; tick();
        irq_lines[3] = 1'b0; tick(); tick();
        rd_check("R2 pend after pulse", 8'h40, 32'h8);
        check("R2 req_vec bit3", 64'(req_vec), 64'h8);

        // R3: more pulses, then one acknowledge
        repeat (2) begin
            irq_lines[3] = 1'b1; tick();
            irq_lines[3] = 1'b0; tick();
        end
        do_ack(3);
        check("R7 active after ack", 64'(active_vec), 64'h8);
        rd_check("R7 pend cleared by ack", 8'h60, 32'h0);
        tick(); tick(); tick();
        check("R3 single request", 64'(req_vec), 64'h0);

        // R8: return with line low
        do_ret(3);
        check("R8 retired", 64'(active_vec), 64'h0);
        rd_check("R8 no repend when low", 8'h40, 32'h0);

        // R9 steady high through handler, then R8 re-pend at exit
        irq_lines[3] = 1'b1; tick();
        do_ack(3);
        tick(); tick(); tick();
        rd_check("R9 steady high no pend", 8'h40, 32'h0);
        do_ret(3);
        rd_check("R8 repend at exit", 8'h40, 32'h8);
        check("R8 inactive after ret", 64'(active_vec), 64'h0);

        // R9: new edge inside handler
        irq_lines[3] = 1'b0;
        do_ack(3);
        rd_check("R7 ack clears", 8'h40, 32'h0);
        irq_lines[3] = 1'b1; tick();
        irq_lines[3] = 1'b0; tick();
        rd_check("R9 edge in handler pends", 8'h40, 32'h8);
        do_ret(3);

        // R5: software clear cancels, software set pends
        wr_reg(8'h60, 32'h8);
        rd_check("R5 clear cancels", 8'h40, 32'h0);
        wr_reg(8'h40, 32'h10);
        rd_check("R5 set pends", 8'h60, 32'h10);
        wr_reg(8'h60, 32'h10);
        rd_check("R5 cleared again", 8'h40, 32'h0);

        // R10: edge and clear in the same cycle
        irq_lines[5] = 1'b1;
        wr_reg(8'h60, 32'h20);
        rd_check("R10 set wins", 8'h40, 32'h20);
        irq_lines[5] = 1'b0;
        tick();
        wr_reg(8'h60, 32'h20);
        rd_check("R10 later clear works", 8'h40, 32'h0);

        // R6: trigger by number
        wr_reg(8'hA0, 32'd35);
        rd_check("R6 trigger 35", 8'h41, 32'h8);
        wr_reg(8'hA0, 32'd40);
        rd_check("R6 out of range w1", 8'h41, 32'h8);
        rd_check("R6 out of range w0", 8'h40, 32'h0);
        wr_reg(8'h61, 32'h8);

        // R11: active read-only, unused space reads 0
        wr_reg(8'h01, 32'hFFFF_FFFF);
        rd_check("R11 bits above N", 8'h21, 32'hFF);
        wr_reg(8'h80, 32'hFFFF_FFFF);
        rd_check("R11 active write ignored", 8'h80, 32'h0);
        rd_check("R11 region 6", 8'hC0, 32'h0);
        rd_check("R11 word 2", 8'h42, 32'h0);

        // Random phase
        for (int n = 0; n < 4000; n++) begin
            logic [63:0] flip;
            int r;
            flip = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
            irq_lines = irq_lines ^ flip[N-1:0];
            r = $urandom_range(0, 3);
            bus_wr = (r == 0);
            bus_addr = {3'($urandom_range(0, 7)), 5'($urandom_range(0, 2))};
            if (bus_addr[7:5] == 3'd5)
                bus_wdata = 32'($urandom_range(0, 47));
            else
                bus_wdata = $urandom & $urandom;
            ack_valid = ($urandom_range(0, 7) == 0);
            ack_id    = IDW'($urandom_range(0, N - 1));
            ret_valid = ($urandom_range(0, 7) == 0);
            ret_id    = IDW'($urandom_range(0, N - 1));
            #1;
            check("R11 random readback", 64'(bus_rdata), 64'(model_read(bus_addr)));
            tick();
        end
        idle();

        summary();
        $finish;
    end

endmodule